// File: doc/BRIEF.md
# Reconfiguration Host Arbiter

This block lets a parameterised number of reconfiguration hosts, from 1 to 32, share one memory-mapped port into a reconfiguration engine. Every host has its own write and read strobes, address, write data, read data, read-valid and waitrequest. The block grants one host at a time in round-robin order. It forwards that host's command to the engine and routes the engine's response back to that host alone.

The engine also signals that a new configuration has been applied. The block passes that event only to the hosts whose enable bit is set. It collects their individual acknowledges and returns a single acknowledge pulse once every enabled host has answered. A parameter can place one register stage on the engine side of the bus to ease timing.

Top module: `rcfg_host_arbiter`

## Requirements
- R1: While reset (synchronous, active high) is asserted and in the first cycle after it, every host waitrequest is high, engine write and read are low, no host read-valid is set and the engine acknowledge is low.
- R2: A grant goes to the first requesting host (write or read high) found by scanning indices cyclically upward from the last granted index plus one. The last granted index is 0 after reset.
- R3: A command is presented to the engine in the cycle after the request is seen in the idle state, with the granted host's address and write data. It stays unchanged while the engine waitrequest is high.
- R4: A host's waitrequest is low only in the cycle in which the engine accepts that host's command (command presented, engine waitrequest low). All other host waitrequests are high, requesting or not.
- R5: After an accepted read, the grant is held and no new command is issued until the engine read-valid arrives. Read-valid and read data reach only the host that issued the read, and every other host's read data is zero.
- R6: An engine read-valid that arrives with no read outstanding reaches no host.
- R7: The engine's applied event appears, in the same cycle, on exactly the hosts whose enable bit is set.
- R8: The engine acknowledge is a one-cycle pulse in the cycle after the last enabled host has acknowledged. Acknowledges from disabled hosts are ignored. With no host enabled, the pulse follows the applied event by one cycle.
- R9: With the pipeline stage on, the engine command comes from registers with the same cycle timing as without it, and read-valid and read data reach the host one cycle after the engine read-valid instead of in the same cycle.
- R10: A host with write and read both high is served as a write, and no read is left outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostEnable | input | NUM_HOSTS | Per-host enable for applied-event routing |
| hostWrite | input | NUM_HOSTS | Per-host write request |
| hostRead | input | NUM_HOSTS | Per-host read request |
| hostAddr | input | NUM_HOSTS*ADDR_W | Per-host address, host i at slice i |
| hostWdata | input | NUM_HOSTS*DATA_W | Per-host write data |
| hostRdata | output | NUM_HOSTS*DATA_W | Per-host read data, zero unless valid |
| hostRvalid | output | NUM_HOSTS | Per-host read data valid |
| hostWait | output | NUM_HOSTS | Per-host waitrequest |
| hostApplied | output | NUM_HOSTS | Applied event to enabled hosts |
| hostAppliedAck | input | NUM_HOSTS | Per-host acknowledge of applied event |
| engWrite | output | 1 | Engine write strobe |
| engRead | output | 1 | Engine read strobe |
| engAddr | output | ADDR_W | Engine address |
| engWdata | output | DATA_W | Engine write data |
| engRdata | input | DATA_W | Engine read data |
| engRvalid | input | 1 | Engine read data valid |
| engWait | input | 1 | Engine waitrequest |
| engApplied | input | 1 | Engine applied-configuration pulse |
| engAppliedAck | output | 1 | Combined acknowledge to engine |

## Verification
The bus path and the applied-event handshake run independently, so the acknowledge pulse can fall in the same cycle as a read return. The bench issues a read from one host and raises the applied event while that read is being accepted. It has the same host acknowledge at once and returns engine read-valid in the following cycle. In that cycle the acknowledge pulse and the read-valid to the issuing host must both be seen, and neither may disturb the other.

// File: rtl/rcfg_arb_pkg.sv
package rcfg_arb_pkg;
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_RDWAIT = 2'd2
  } arbState_t;

  typedef struct packed {
    logic             issue;
    logic             isRead;
    logic             issueNext;
    logic             isReadNext;
    logic             grantLoad;
    logic             rdWait;
    logic [IDX_W-1:0] grantIdx;
    logic [IDX_W-1:0] grantNext;
  } arbStrobe_t;
endpackage

// File: rtl/rcfg_arb_ctrl.sv
module rcfg_arb_ctrl
  import rcfg_arb_pkg::*;
#(
  parameter int NUM_HOSTS = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_HOSTS-1:0] hostWrite,
  input  logic [NUM_HOSTS-1:0] hostRead,
  input  logic [NUM_HOSTS-1:0] hostEnable,
  input  logic [NUM_HOSTS-1:0] hostAppliedAck,
  input  logic                 engWait,
  input  logic                 engRvalid,
  input  logic                 engApplied,
  output arbStrobe_t           strobe,
  output logic                 engAppliedAck
);
  localparam logic [NUM_HOSTS-1:0] ONE = NUM_HOSTS'(1);

  arbState_t        stateQ, stateN;
  logic [IDX_W-1:0] grantQ, grantN, winIdx;
  logic             isReadQ, isReadN, winFound, grantLoad;
  logic [NUM_HOSTS-1:0] reqVec;

  assign reqVec = hostWrite | hostRead;

  // round-robin scan starting after the last grant
  always_comb begin
    winFound = 1'b0;
    winIdx   = grantQ;
    for (int k = 1; k <= NUM_HOSTS; k++) begin
      if (!winFound && |(reqVec & (ONE << ((int'(grantQ) + k) % NUM_HOSTS)))) begin
        winFound = 1'b1;
        winIdx   = IDX_W'((int'(grantQ) + k) % NUM_HOSTS);
      end
    end
  end

  always_comb begin
    stateN    = stateQ;
    grantN    = grantQ;
    isReadN   = isReadQ;
    grantLoad = 1'b0;
    case (stateQ)
      ST_IDLE: if (winFound) begin
        stateN    = ST_ISSUE;
        grantN    = winIdx;
        isReadN   = |(hostRead & ~hostWrite & (ONE << winIdx));
        grantLoad = 1'b1;
      end
      ST_ISSUE:  if (!engWait) stateN = isReadQ ? ST_RDWAIT : ST_IDLE;
      ST_RDWAIT: if (engRvalid) stateN = ST_IDLE;
      default:   stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      grantQ  <= '0;
      isReadQ <= 1'b0;
    end else begin
      stateQ  <= stateN;
      grantQ  <= grantN;
      isReadQ <= isReadN;
    end
  end

  assign strobe.issue      = (stateQ == ST_ISSUE);
  assign strobe.isRead     = isReadQ;
  assign strobe.issueNext  = (stateN == ST_ISSUE);
  assign strobe.isReadNext = isReadN;
  assign strobe.grantLoad  = grantLoad;
  assign strobe.rdWait     = (stateQ == ST_RDWAIT);
  assign strobe.grantIdx   = grantQ;
  assign strobe.grantNext  = grantN;

  // applied-event acknowledge collection
  logic                 pendQ, pendNow, allDone, ackQ;
  logic [NUM_HOSTS-1:0] ackSeenQ, enAcks;

  assign pendNow = pendQ | engApplied;
  assign enAcks  = hostAppliedAck & hostEnable;
  assign allDone = pendNow && (((ackSeenQ | enAcks) & hostEnable) == hostEnable);

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ    <= 1'b0;
      ackSeenQ <= '0;
      ackQ     <= 1'b0;
    end else begin
      ackQ     <= allDone;
      pendQ    <= pendNow & ~allDone;
      ackSeenQ <= (allDone || !pendNow) ? '0 : (ackSeenQ | enAcks);
    end
  end

  assign engAppliedAck = ackQ;
endmodule

// File: rtl/rcfg_arb_datapath.sv
module rcfg_arb_datapath
  import rcfg_arb_pkg::*;
#(
  parameter int NUM_HOSTS = 1,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int PIPE_EN   = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  arbStrobe_t                  strobe,
  input  logic [NUM_HOSTS-1:0]        hostEnable,
  input  logic [NUM_HOSTS*ADDR_W-1:0] hostAddr,
  input  logic [NUM_HOSTS*DATA_W-1:0] hostWdata,
  output logic [NUM_HOSTS*DATA_W-1:0] hostRdata,
  output logic [NUM_HOSTS-1:0]        hostRvalid,
  output logic [NUM_HOSTS-1:0]        hostWait,
  output logic [NUM_HOSTS-1:0]        hostApplied,
  output logic                        engWrite,
  output logic                        engRead,
  output logic [ADDR_W-1:0]           engAddr,
  output logic [DATA_W-1:0]           engWdata,
  input  logic [DATA_W-1:0]           engRdata,
  input  logic                        engRvalid,
  input  logic                        engWait,
  input  logic                        engApplied
);
  localparam logic [NUM_HOSTS-1:0] ONE = NUM_HOSTS'(1);

  logic [NUM_HOSTS-1:0] grantOh, retOh, rvSel;
  logic [DATA_W-1:0]    rdataSel;
  logic                 accept;

  assign grantOh     = ONE << strobe.grantIdx;
  assign accept      = strobe.issue & ~engWait;
  assign hostWait    = ~(grantOh & {NUM_HOSTS{accept}});
  assign retOh       = grantOh & {NUM_HOSTS{strobe.rdWait & engRvalid}};
  assign hostApplied = hostEnable & {NUM_HOSTS{engApplied}};

  generate
    if (PIPE_EN != 0) begin : g_pipe
      logic              wrQ, rdQ;
      logic [ADDR_W-1:0] addrQ;
      logic [DATA_W-1:0] wdQ, rdataQ;
      logic [NUM_HOSTS-1:0] rvQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          wrQ <= 1'b0; rdQ <= 1'b0; addrQ <= '0; wdQ <= '0;
          rvQ <= '0; rdataQ <= '0;
        end else begin
          wrQ    <= strobe.issueNext & ~strobe.isReadNext;
          rdQ    <= strobe.issueNext & strobe.isReadNext;
          rvQ    <= retOh;
          rdataQ <= engRdata;
          if (strobe.grantLoad) begin
            addrQ <= ADDR_W'(hostAddr >> (int'(strobe.grantNext) * ADDR_W));
            wdQ   <= DATA_W'(hostWdata >> (int'(strobe.grantNext) * DATA_W));
          end
        end
      end
      assign engWrite = wrQ;
      assign engRead  = rdQ;
      assign engAddr  = addrQ;
      assign engWdata = wdQ;
      assign rvSel    = rvQ;
      assign rdataSel = rdataQ;
    end else begin : g_comb
      logic pipeUnused;
      assign pipeUnused = ^{clk, rst, strobe.issueNext, strobe.isReadNext,
                            strobe.grantLoad, strobe.grantNext};
      assign engWrite = strobe.issue & ~strobe.isRead;
      assign engRead  = strobe.issue & strobe.isRead;
      assign engAddr  = ADDR_W'(hostAddr >> (int'(strobe.grantIdx) * ADDR_W));
      assign engWdata = DATA_W'(hostWdata >> (int'(strobe.grantIdx) * DATA_W));
      assign rvSel    = retOh;
      assign rdataSel = engRdata;
    end
  endgenerate

  assign hostRvalid = rvSel;

  generate
    for (genvar i = 0; i < NUM_HOSTS; i++) begin : g_ret
      assign hostRdata[i*DATA_W +: DATA_W] = rvSel[i] ? rdataSel : '0;
    end
  endgenerate
endmodule

// File: rtl/rcfg_host_arbiter.sv
module rcfg_host_arbiter
  import rcfg_arb_pkg::*;
#(
  parameter int NUM_HOSTS = 1,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int PIPE_EN   = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_HOSTS-1:0]        hostEnable,
  input  logic [NUM_HOSTS-1:0]        hostWrite,
  input  logic [NUM_HOSTS-1:0]        hostRead,
  input  logic [NUM_HOSTS*ADDR_W-1:0] hostAddr,
  input  logic [NUM_HOSTS*DATA_W-1:0] hostWdata,
  output logic [NUM_HOSTS*DATA_W-1:0] hostRdata,
  output logic [NUM_HOSTS-1:0]        hostRvalid,
  output logic [NUM_HOSTS-1:0]        hostWait,
  output logic [NUM_HOSTS-1:0]        hostApplied,
  input  logic [NUM_HOSTS-1:0]        hostAppliedAck,
  output logic                        engWrite,
  output logic                        engRead,
  output logic [ADDR_W-1:0]           engAddr,
  output logic [DATA_W-1:0]           engWdata,
  input  logic [DATA_W-1:0]           engRdata,
  input  logic                        engRvalid,
  input  logic                        engWait,
  input  logic                        engApplied,
  output logic                        engAppliedAck
);
  arbStrobe_t strobe;

  rcfg_arb_ctrl #(.NUM_HOSTS(NUM_HOSTS)) u_ctrl (
    .clk(clk), .rst(rst),
    .hostWrite(hostWrite), .hostRead(hostRead),
    .hostEnable(hostEnable), .hostAppliedAck(hostAppliedAck),
    .engWait(engWait), .engRvalid(engRvalid), .engApplied(engApplied),
    .strobe(strobe), .engAppliedAck(engAppliedAck)
  );

  rcfg_arb_datapath #(
    .NUM_HOSTS(NUM_HOSTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPE_EN(PIPE_EN)
  ) u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .hostEnable(hostEnable), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .hostWait(hostWait),
    .hostApplied(hostApplied),
    .engWrite(engWrite), .engRead(engRead), .engAddr(engAddr), .engWdata(engWdata),
    .engRdata(engRdata), .engRvalid(engRvalid), .engWait(engWait),
    .engApplied(engApplied)
  );
endmodule

// File: rtl/rcfg_host_arbiter_chk.sv
module rcfg_host_arbiter_chk #(
  parameter int NUM_HOSTS = 1,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_HOSTS-1:0] hostWait,
  input logic [NUM_HOSTS-1:0] hostRvalid,
  input logic                 engWrite,
  input logic                 engRead,
  input logic [ADDR_W-1:0]    engAddr,
  input logic [DATA_W-1:0]    engWdata,
  input logic                 engWait,
  input logic                 engAppliedAck
);
  p_single_accept_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~hostWait));

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (engWrite || engRead) && engWait |=>
      (engWrite == $past(engWrite)) && (engRead == $past(engRead)) &&
      $stable(engAddr) && $stable(engWdata));

  p_excl_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    !(engWrite && engRead));

  p_one_return_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hostRvalid));

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    engAppliedAck |=> !engAppliedAck);
endmodule

bind rcfg_host_arbiter rcfg_host_arbiter_chk #(
  .NUM_HOSTS(NUM_HOSTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .hostWait(hostWait), .hostRvalid(hostRvalid),
  .engWrite(engWrite), .engRead(engRead), .engAddr(engAddr), .engWdata(engWdata),
  .engWait(engWait), .engAppliedAck(engAppliedAck)
);

// File: tb/test_rcfg_host_arbiter.sv
module test_rcfg_host_arbiter;
  localparam int NH = 4;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NH-1:0]    hostEnable = '0, hostWrite = '0, hostRead = '0, hostAppliedAck = '0;
  logic [NH*AW-1:0] hostAddr;
  logic [NH*DW-1:0] hostWdata;
  logic [DW-1:0]    engRdata = '0;
  logic             engRvalid = 1'b0, engWait = 1'b0, engApplied = 1'b0;

  logic [NH*DW-1:0] hostRdata0, hostRdata1;
  logic [NH-1:0]    hostRvalid0, hostRvalid1, hostWait0, hostWait1, hostApplied0, hostApplied1;
  logic             engWrite0, engWrite1, engRead0, engRead1, engAck0, engAck1;
  logic [AW-1:0]    engAddr0, engAddr1;
  logic [DW-1:0]    engWdata0, engWdata1;

  rcfg_host_arbiter #(.NUM_HOSTS(NH), .ADDR_W(AW), .DATA_W(DW), .PIPE_EN(0)) i_rcfg_host_arbiter (
    .clk(clk), .rst(rst), .hostEnable(hostEnable), .hostWrite(hostWrite), .hostRead(hostRead),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata0), .hostRvalid(hostRvalid0),
    .hostWait(hostWait0), .hostApplied(hostApplied0), .hostAppliedAck(hostAppliedAck),
    .engWrite(engWrite0), .engRead(engRead0), .engAddr(engAddr0), .engWdata(engWdata0),
    .engRdata(engRdata), .engRvalid(engRvalid), .engWait(engWait), .engApplied(engApplied),
    .engAppliedAck(engAck0));

  rcfg_host_arbiter #(.NUM_HOSTS(NH), .ADDR_W(AW), .DATA_W(DW), .PIPE_EN(1)) i_rcfg_host_arbiter_pipe (
    .clk(clk), .rst(rst), .hostEnable(hostEnable), .hostWrite(hostWrite), .hostRead(hostRead),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata1), .hostRvalid(hostRvalid1),
    .hostWait(hostWait1), .hostApplied(hostApplied1), .hostAppliedAck(hostAppliedAck),
    .engWrite(engWrite1), .engRead(engRead1), .engAddr(engAddr1), .engWdata(engWdata1),
    .engRdata(engRdata), .engRvalid(engRvalid), .engWait(engWait), .engApplied(engApplied),
    .engAppliedAck(engAck1));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int last;
    for (int i = 0; i < NH; i++) begin
      hostAddr[i*AW +: AW]  = AW'(10'h100 + i);
      hostWdata[i*DW +: DW] = 32'hA5A5_0000 + 32'(i * 17);
    end
    repeat (3) cyc();
    settle();
    chk("R1 wait in reset", 128'(hostWait0), 128'hF);
    rst = 1'b0;
    cyc(); settle();
    chk("R1 wait after reset", 128'({hostWait0, hostWait1}), 128'hFF);
    chk("R1 engine cmd after reset", 128'({engWrite0, engRead0, engWrite1, engRead1}), 128'h0);
    chk("R1 rvalid and ack after reset", 128'({hostRvalid0, hostRvalid1, engAck0, engAck1}), 128'h0);

    // R2 sweep every request mask
    last = 0;
    for (int m = 1; m < 16; m++) begin
      int expIdx;
      expIdx = -1;
      for (int k = 1; k <= NH; k++)
        if (expIdx < 0 && m[(last + k) % NH]) expIdx = (last + k) % NH;
      cyc(); hostWrite = 4'(m); settle();
      chk("R3 idle cycle before issue", 128'(engWrite0), 128'h0);
      cyc(); settle();
      chk("R2 round-robin winner", 128'(hostWait0), 128'(4'(~(4'b0001 << expIdx))));
      chk("R3 engine address", 128'(engAddr0), 128'(10'h100 + expIdx));
      chk("R3 engine write data", 128'(engWdata0), 128'(32'hA5A5_0000 + 32'(expIdx * 17)));
      chk("R9 pipelined command timing", 128'({engWrite1, engAddr1, hostWait1}),
          128'({1'b1, engAddr0, hostWait0}));
      hostWrite = '0;
      cyc(); settle();
      chk("R4 wait high after accept", 128'({hostWait0, engWrite0}), 128'h1E);
      last = expIdx;
    end

    // R3/R4 stall with a competing host
    cyc(); hostWrite = 4'b0100; engWait = 1'b1; settle();
    cyc(); settle();
    chk("R3 command under stall", 128'({engWrite0, engAddr0}), 128'({1'b1, 10'h102}));
    chk("R4 stalled host waits", 128'(hostWait0), 128'hF);
    hostWrite = 4'b0101;
    for (int s = 0; s < 2; s++) begin
      cyc(); settle();
      chk("R3 command held", 128'({engWrite0, engAddr0, engWdata0}),
          128'({1'b1, 10'h102, 32'hA5A5_0022}));
      chk("R4 no accept during stall", 128'({hostWait0, hostWait1}), 128'hFF);
    end
    engWait = 1'b0; settle();
    chk("R4 accept releases granted host only", 128'(hostWait0), 128'hB);
    hostWrite = 4'b0001;
    cyc(); settle();
    chk("R3 idle between grants", 128'(engWrite0), 128'h0);
    cyc(); settle();
    chk("R2 pending host served next", 128'({engAddr0, hostWait0}), 128'({10'h100, 4'hE}));
    hostWrite = '0;
    cyc();

    // R5/R9 read path
    hostRead = 4'b1000; settle();
    cyc(); settle();
    chk("R5 read issued", 128'({engRead0, engWrite0, engAddr0, hostWait0}),
        128'({1'b1, 1'b0, 10'h103, 4'h7}));
    hostRead = '0; hostWrite = 4'b0010;
    for (int s = 0; s < 2; s++) begin
      cyc(); settle();
      chk("R5 grant held during read", 128'({engRead0, engWrite0, hostRvalid0, hostWait0}),
          128'({2'b00, 4'h0, 4'hF}));
    end
    engRvalid = 1'b1; engRdata = 32'hCAFE_0123; settle();
    chk("R5 read return to issuer", 128'(hostRvalid0), 128'h8);
    chk("R5 read data only to issuer", 128'(hostRdata0), {32'hCAFE_0123, 96'h0});
    chk("R9 pipelined return not yet", 128'(hostRvalid1), 128'h0);
    cyc(); engRvalid = 1'b0; settle();
    chk("R9 pipelined return one cycle later", 128'({hostRvalid1, hostRdata1}),
        {4'h8, 32'hCAFE_0123, 96'h0});
    chk("R5 return is single cycle", 128'({hostRvalid0, engWrite0}), 128'h0);
    cyc(); settle();
    chk("R5 waiting host served after return", 128'({engWrite0, engAddr0, hostWait0}),
        128'({1'b1, 10'h101, 4'hD}));
    hostWrite = '0;
    cyc();

    // R6 stray read-valid
    engRvalid = 1'b1; engRdata = 32'h0BAD_F00D; settle();
    chk("R6 stray read-valid", 128'({hostRvalid0, hostRdata0}), 128'h0);
    cyc(); engRvalid = 1'b0; settle();
    chk("R6 stray read-valid pipelined", 128'({hostRvalid1, hostRdata1}), 128'h0);

    // R10 write and read together
    hostWrite = 4'b0001; hostRead = 4'b0001;
    cyc(); settle();
    chk("R10 served as write", 128'({engWrite0, engRead0, engAddr0}), 128'({2'b10, 10'h100}));
    hostWrite = '0; hostRead = '0;
    cyc(); hostWrite = 4'b0100; settle();
    chk("R10 back to idle", 128'({engWrite0, engRead0}), 128'h0);
    cyc(); settle();
    chk("R10 no read outstanding", 128'({engWrite0, engAddr0}), 128'({1'b1, 10'h102}));
    hostWrite = '0;

    // R7/R8 sweep every enable mask
    for (int e = 0; e < 16; e++) begin
      cyc(); hostEnable = 4'(e); engApplied = 1'b1; hostAppliedAck = 4'(~e); settle();
      chk("R7 applied to enabled hosts", 128'({hostApplied0, hostApplied1}), 128'({4'(e), 4'(e)}));
      chk("R8 no ack on event cycle", 128'(engAck0), 128'h0);
      cyc(); engApplied = 1'b0; hostAppliedAck = '0; settle();
      chk("R7 applied only with event", 128'(hostApplied0), 128'h0);
      chk("R8 ack after event with empty mask", 128'(engAck0), 128'(e == 0));
      for (int b = 0; b < NH; b++) begin
        if (e[b]) begin
          hostAppliedAck = 4'(1 << b);
          cyc(); hostAppliedAck = '0; settle();
          chk("R8 ack after last enabled host", 128'({engAck0, engAck1}),
              128'(((e & ~((2 << b) - 1)) == 0) ? 2'b11 : 2'b00));
        end
      end
      cyc(); settle();
      chk("R8 ack is one cycle", 128'({engAck0, engAck1}), 128'h0);
    end

    // overlap: ack pulse and read return in one cycle
    hostEnable = 4'b0010; hostRead = 4'b0010;
    cyc(); settle();
    chk("R5 overlap read issued", 128'({engRead0, hostWait0}), 128'({1'b1, 4'hD}));
    hostRead = '0; engApplied = 1'b1; hostAppliedAck = 4'b0010; settle();
    chk("R7 overlap applied", 128'(hostApplied0), 128'h2);
    cyc(); engApplied = 1'b0; hostAppliedAck = '0; engRvalid = 1'b1; engRdata = 32'h1234_5678; settle();
    chk("R8 overlap ack", 128'(engAck0), 128'h1);
    chk("R5 overlap read return", 128'({hostRvalid0, hostRdata0}),
        {4'h2, 64'h0, 32'h1234_5678, 32'h0});
    cyc(); engRvalid = 1'b0; settle();
    chk("R9 overlap pipelined return", 128'({hostRvalid1, engAck0}), 128'({4'h2, 1'b0}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule